// File: doc/BRIEF.md
# Receive Frame Length Checker

This block measures each received frame in bytes and sorts it against two programmable limits. The count starts at the first byte after the start-frame delimiter and ends at the last byte of the frame. An upstream deserializer marks these bytes with a start marker and an end marker, both qualified by a byte strobe. When the last byte arrives, the block compares the final count against an upper bound and a lower bound. It then presents a single-cycle status word: the length, an oversize flag, an undersize flag and a drop indication. A buffer manager downstream folds this word into the final buffer descriptor.

The two limits are not handled alike. An oversize frame is counted in full and accepted; only its flag is raised. An undersize frame is marked for dropping, unless the keep-short input is high. In that case the frame is kept, and its undersize flag tells software what happened. The counter stops at its all-ones value instead of wrapping, so a runaway frame still reports as oversize.

Top module: `rx_len_check`

## Requirements
- R1: After reset, and until the first status cycle, `st_vld`, `st_len`, `st_long`, `st_short` and `st_drop` are all zero.
- R2: The reported length is the number of cycles with `byte_vld` high, from the byte carrying `sof` up to and including the byte carrying `eof`. A byte that carries both markers gives a length of 1.
- R3: The length saturates at 16'hFFFF: a frame with more bytes than that reports 16'hFFFF.
- R4: `st_long` is 1 exactly when the length is greater than `max_len`. A length equal to `max_len` is not long, and an oversize frame is still counted to its end, with `st_drop` unaffected by length.
- R5: `st_short` is 1 exactly when the length is less than `min_len`. A length equal to `min_len` is not short.
- R6: `st_drop` is 1 exactly when the frame is short and `keep_short` is 0. With `keep_short` at 1, a short frame reports `st_short`=1 and `st_drop`=0.
- R7: `st_vld` is 1 for exactly the one cycle after each cycle in which a byte with `eof` is accepted. In every other cycle `st_vld` is 0 and all other status outputs read zero.
- R8: `sof` and `eof` are ignored unless `byte_vld` is 1. Bytes and `eof` markers that arrive outside a frame (no `sof` since the last accepted `eof`) are ignored. A `sof` inside a frame restarts the count at 1.
- R9: `max_len`, `min_len` and `keep_short` are sampled only in the cycle of the `eof` byte. Changes earlier in the frame have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_vld | input | 1 | A frame byte is present this cycle |
| sof | input | 1 | This byte is the first after the start-frame delimiter |
| eof | input | 1 | This byte is the last of the frame |
| max_len | input | 16 | Upper length bound, inclusive |
| min_len | input | 16 | Lower length bound, inclusive |
| keep_short | input | 1 | Keep undersize frames instead of dropping them |
| st_vld | output | 1 | Status word valid (one cycle) |
| st_len | output | 16 | Frame length in bytes |
| st_long | output | 1 | Frame exceeded `max_len` |
| st_short | output | 1 | Frame fell below `min_len` |
| st_drop | output | 1 | Frame should be discarded |

## Verification
Two things can fall in the same cycle. The status word of one frame is presented while the counter is already taking the first byte of the next frame. The bench provokes this by sending frames back to back, with no idle cycle between an `eof` byte and the next `sof` byte, including runs of one-byte frames. A behavioural reference model tracks every accepted byte in an unbounded integer and clamps only when it reports. It is compared with the outputs at every falling edge, so a status word disturbed by the restart, or a restart disturbed by the status, shows up at once.

// File: rtl/rx_len_check.sv
module rx_len_check #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_vld,
  input  logic             sof,
  input  logic             eof,
  input  logic [LEN_W-1:0] max_len,
  input  logic [LEN_W-1:0] min_len,
  input  logic             keep_short,
  output logic             st_vld,
  output logic [LEN_W-1:0] st_len,
  output logic             st_long,
  output logic             st_short,
  output logic             st_drop
);

  localparam logic [LEN_W-1:0] LEN_TOP = {LEN_W{1'b1}};
  localparam logic [LEN_W-1:0] LEN_ONE = {{(LEN_W-1){1'b0}}, 1'b1};

  logic             in_frame;
  logic [LEN_W-1:0] cnt;
  logic             start;
  logic             take;
  logic             done;
  logic [LEN_W-1:0] len_now;
  logic             is_long;
  logic             is_short;

  assign start    = byte_vld & sof;
  assign take     = byte_vld & (sof | in_frame);
  assign done     = take & eof;
  assign len_now  = start ? LEN_ONE : (cnt == LEN_TOP) ? cnt : cnt + LEN_ONE;
  assign is_long  = len_now > max_len;
  assign is_short = len_now < min_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      cnt      <= '0;
    end else if (take) begin
      in_frame <= ~eof;
      cnt      <= len_now;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !done) begin
      st_vld   <= 1'b0;
      st_len   <= '0;
      st_long  <= 1'b0;
      st_short <= 1'b0;
      st_drop  <= 1'b0;
    end else begin
      st_vld   <= 1'b1;
      st_len   <= len_now;
      st_long  <= is_long;
      st_short <= is_short;
      st_drop  <= is_short & ~keep_short;
    end
  end

endmodule

module rx_len_check_sva #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             byte_vld,
  input logic             sof,
  input logic             eof,
  input logic [LEN_W-1:0] max_len,
  input logic [LEN_W-1:0] min_len,
  input logic             keep_short,
  input logic             st_vld,
  input logic [LEN_W-1:0] st_len,
  input logic             st_long,
  input logic             st_short,
  input logic             st_drop
);

  AST_SINGLE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && sof && eof) |=> (st_vld && st_len == 1)); // R2

  AST_NO_STRAY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_vld && eof) |=> !st_vld); // R7

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !st_vld |-> (st_len == 0 && !st_long && !st_short && !st_drop)); // R7

  AST_DROP_NEEDS_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_vld && st_drop) |-> st_short); // R6

  AST_KEEP_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && eof && keep_short) |=> !st_drop); // R6

  AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    st_vld |-> st_len != 0); // R2

  AST_LONG_ABOVE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && eof && max_len == {LEN_W{1'b1}}) |=> !st_long); // R4

  AST_SHORT_BELOW_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && eof && min_len <= 1) |=> !st_short); // R5

endmodule

bind rx_len_check rx_len_check_sva #(.LEN_W(LEN_W)) u_sva (.*);

// File: tb/rx_len_check_test.sv
module rx_len_check_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byte_vld = 1'b0;
  logic        sof = 1'b0;
  logic        eof = 1'b0;
  logic [15:0] max_len = 16'd1518;
  logic [15:0] min_len = 16'd64;
  logic        keep_short = 1'b0;
  logic        st_vld;
  logic [15:0] st_len;
  logic        st_long;
  logic        st_short;
  logic        st_drop;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string scen = "R1";
  int eof_max = -1;

  int     m_cnt = 0;
  bit     m_in = 0;
  bit     e_vld = 0;
  int     e_len = 0;
  bit     e_long = 0, e_short = 0, e_drop = 0;

  always #10 clk = ~clk;

  rx_len_check uut (.*);

  always @(posedge clk) begin
    e_vld = 0; e_len = 0; e_long = 0; e_short = 0; e_drop = 0;
    if (!rst_n) begin
      m_cnt = 0; m_in = 0;
    end else if (byte_vld && (sof || m_in)) begin
      m_cnt = sof ? 1 : m_cnt + 1;
      m_in = 1;
      if (eof) begin
        m_in = 0;
        e_vld = 1;
        e_len = (m_cnt > 65535) ? 65535 : m_cnt;
        e_long = e_len > int'(max_len);
        e_short = e_len < int'(min_len);
        e_drop = e_short && !keep_short;
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s [%s] at cycle %0d: actual %0d expected %0d", req, scen, cycles, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk("R7 vld", st_vld, e_vld);
      chk("R2 len", st_len, e_len);
      chk("R4 long", st_long, e_long);
      chk("R5 short", st_short, e_short);
      chk("R6 drop", st_drop, e_drop);
    end
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      byte_vld = 0; sof = 0; eof = 0;
    end
  endtask

  task automatic frame(int n, int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      byte_vld = 1; sof = (i == 0); eof = (i == n - 1);
      if (eof && eof_max >= 0) max_len = 16'(eof_max);
      if (gap > 0 && (i % gap) == gap - 1 && i != n - 1) begin
        @(negedge clk);
        byte_vld = 0; sof = 1; eof = 1;
      end
    end
  endtask

  initial begin
    idle(3);
    chk("R1 vld", st_vld, 0);
    chk("R1 len", st_len, 0);
    @(negedge clk); rst_n = 1;
    idle(2);

    scen = "R2 basic";   frame(10, 0); frame(100, 7); idle(3);
    scen = "R4 boundary"; frame(1518, 0); frame(1519, 0); frame(3000, 13); idle(3);
    scen = "R5 boundary"; frame(64, 0); frame(63, 0); frame(1, 0); idle(2);
    scen = "R6 keep";    keep_short = 1; frame(63, 0); frame(5, 3); keep_short = 0; frame(5, 0); idle(2);
    scen = "R7 back2back"; for (int k = 0; k < 6; k++) frame(1, 0); frame(70, 0); frame(2, 0); frame(64, 0); idle(3);

    scen = "R8 stray";
    @(negedge clk); byte_vld = 1; sof = 0; eof = 0;
    @(negedge clk); byte_vld = 1; sof = 0; eof = 1;
    @(negedge clk); byte_vld = 0; sof = 1; eof = 1;
    idle(2);
    frame(20, 0);
    @(negedge clk); byte_vld = 1; sof = 0; eof = 1;
    idle(2);
    scen = "R8 restart";
    frame(30, 0);
    idle(1);
    frame(50, 0);
    idle(2);
    @(negedge clk); byte_vld = 1; sof = 1; eof = 0;
    @(negedge clk); byte_vld = 1; sof = 0; eof = 0;
    @(negedge clk); byte_vld = 1; sof = 1; eof = 0;
    @(negedge clk); byte_vld = 1; sof = 0; eof = 1;
    idle(3);

    scen = "R9 late limits";
    max_len = 16'd10; eof_max = 20; frame(15, 0); idle(2);
    eof_max = 12; frame(15, 0); idle(2);
    eof_max = -1; max_len = 16'd1518;
    @(negedge clk); byte_vld = 1; sof = 1; eof = 0; min_len = 16'd2;
    @(negedge clk); byte_vld = 1; sof = 0; eof = 0; min_len = 16'd64;
    @(negedge clk); byte_vld = 1; sof = 0; eof = 1; keep_short = 1;
    idle(2); keep_short = 0;

    scen = "R3 saturate";
    frame(65540, 0); idle(2);
    max_len = 16'hFFFF;
    frame(65536, 0); idle(3);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule